// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block generates the frequency-deviation profile that spreads a synthesized clock over a narrow band and lowers its peak emission. It runs on the reference clock. Each modulation cycle is a symmetric triangle: the deviation climbs from zero to a positive peak, falls through zero to the negative peak, and climbs back to zero, all in equal amplitude steps. The signed deviation word, in parts per million, goes to a current-output DAC that nudges the oscillator. A one-cycle strobe marks every change of the word.

The peak comes from a 3-bit rate code. The cycle length comes from a 3-bit period selector. Successive cycles deliberately differ in length. They walk through five multipliers of the period factor and then repeat, so the modulation tone smears instead of sitting at one frequency. Inside a cycle the steps are spread evenly by a remainder accumulator, so each cycle has exactly its nominal length. Two mode inputs stop modulation at once: one for plain phase-locked operation and one for the case where the reference itself is routed to the output. A change to the rate or period input is applied only at a cycle boundary.

Top module: `ssc_profile_gen`

## Requirements
- R1: While reset is asserted, and after its release until the first step, `dev_ppm` is 0 and `dev_upd` is 0.
- R2: Every cycle has 40 steps. After step p (1..40) the deviation is level(p) × u, where u = rate_code × 250 ppm and level(p) is p for p ≤ 10, 20−p for p ≤ 30, and p−40 otherwise. `dev_upd` is high for exactly the clock after each step, and `dev_ppm` changes only then.
- R3: The peak deviation is rate_code × 2500 ppm: 000 gives 0 (no modulation, though the steps still occur), 001 gives 2500, and so on up to 111, which gives 17500. |dev_ppm| never exceeds 17500.
- R4: Cycle lengths, measured in reference clocks between the last steps of successive cycles, follow the multipliers 224, 245, 266, 287, 308 of (S+1), where S is the period selector, and then repeat. The first cycle after a start uses 224 and ends 224·(S+1)+1 clocks after the start.
- R5: A period selector value of 0 behaves as 1.
- R6: A change of rate_code or period_sel made during a cycle leaves the rest of that cycle unchanged and takes effect from the next cycle.
- R7: While `pll_mode` is 1, `dev_ppm` is 0 from the next clock on, and no strobes occur.
- R8: While `src_bypass` is 1, `dev_ppm` is 0 from the next clock on, and no strobes occur.
- R9: After both mode inputs return to 0, the profile restarts from zero deviation. Its first cycle uses the 224 multiplier and the current inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rate_code | input | 3 | Peak deviation code (peak = code × 2500 ppm) |
| period_sel | input | 3 | Cycle length factor S (0 treated as 1) |
| pll_mode | input | 1 | 1 forces modulation off |
| src_bypass | input | 1 | 1 (reference routed to output) forces modulation off |
| dev_ppm | output | 16 | Signed deviation in ppm |
| dev_upd | output | 1 | One-clock pulse when dev_ppm has been updated |

## Verification
The bench measures each cycle length to the exact clock across a full multiplier round and its wrap. A design that dropped or added one accumulator remainder, or that restarted the walk in the wrong place, would be off by a clock or would show the wrong multiplier. It changes the rate and the period mid-cycle and checks that the old peak and old length finish the cycle; a design that sampled its inputs continuously would jump in the middle of the triangle. It checks selector 0 against the length for selector 1, and the longest setting. It asserts each mode input with a nonzero deviation showing, and expects zero on the next clock, silence while the input is held, and a restart from the 224 multiplier. A design that held the last word, or resumed mid-profile, would fail these checks.

// File: rtl/ssc_prof_pkg.sv
package ssc_prof_pkg;

   // Direction of the triangle for the step taken from position pos (0-based).
   function automatic logic tri_climbing(input int unsigned pos, input int unsigned quarter);
      return (pos < quarter) || (pos >= 3 * quarter);
   endfunction

   // Period selector with the zero code folded onto one.
   function automatic int unsigned sel_effective(input int unsigned sel);
      return (sel == 0) ? 1 : sel;
   endfunction

endpackage

// File: rtl/ssc_cycle_sched.sv
module ssc_cycle_sched #(
   parameter int MULT_BASE  = 224,
   parameter int MULT_STEP  = 21,
   parameter int MULT_COUNT = 5,
   parameter int SEL_W      = 3,
   parameter int LEN_W      = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             load,
   input  logic [SEL_W-1:0] sel,
   output logic [LEN_W-1:0] cyc_len
);
   import ssc_prof_pkg::*;

   localparam int MULT_MAX = MULT_BASE + MULT_STEP * (MULT_COUNT - 1);
   localparam int MUL_W    = $clog2(MULT_MAX + 1);
   localparam int IDX_W    = (MULT_COUNT > 1) ? $clog2(MULT_COUNT) : 1;
   localparam int FAC_W    = SEL_W + 1;

   if (MULT_MAX * (2 ** SEL_W) >= 2 ** LEN_W) begin : g_len_too_narrow
      $error("ssc_cycle_sched: LEN_W too small for the longest cycle");
   end
   if (MULT_COUNT < 1) begin : g_no_mult
      $error("ssc_cycle_sched: MULT_COUNT must be at least 1");
   end

   logic [MUL_W-1:0] mult_cur;
   logic [FAC_W-1:0] factor;
   logic [LEN_W-1:0] len_next;

   generate
      if (MULT_COUNT > 1) begin : g_wander
         logic [IDX_W-1:0] idx_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               idx_q <= '0;
            else if (clear)
               idx_q <= '0;
            else if (load)
               idx_q <= (idx_q == IDX_W'(MULT_COUNT - 1)) ? '0 : idx_q + 1'b1;
         end
         assign mult_cur = MUL_W'(MULT_BASE) + MUL_W'(MULT_STEP) * MUL_W'(idx_q);
      end else begin : g_fixed
         assign mult_cur = MUL_W'(MULT_BASE);
      end
   endgenerate

   assign factor   = FAC_W'(sel_effective(int'(sel))) + FAC_W'(1);
   assign len_next = LEN_W'(mult_cur) * LEN_W'(factor);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cyc_len <= LEN_W'(MULT_BASE);
      else if (load && !clear)
         cyc_len <= len_next;
   end

endmodule

// File: rtl/ssc_step_pacer.sv
module ssc_step_pacer #(
   parameter int STEPS = 40,
   parameter int LEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             run,
   input  logic [LEN_W-1:0] cyc_len,
   output logic             step
);
   localparam int ACC_W = LEN_W + 1;

   if (STEPS >= 2 ** LEN_W) begin : g_steps_too_many
      $error("ssc_step_pacer: STEPS exceeds the cycle length range");
   end

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_sum;
   logic [ACC_W-1:0] len_ext;

   // Remainder accumulator: STEPS events spread evenly over cyc_len clocks.
   assign len_ext = {1'b0, cyc_len};
   assign acc_sum = acc_q + ACC_W'(STEPS);
   assign step    = run && (acc_sum >= len_ext);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_q <= '0;
      else if (clear || !run)
         acc_q <= '0;
      else if (step)
         acc_q <= acc_sum - len_ext;
      else
         acc_q <= acc_sum;
   end

endmodule

// File: rtl/ssc_tri_shaper.sv
module ssc_tri_shaper #(
   parameter int QUARTER = 10,
   parameter int PPM_W   = 11,
   parameter int DEV_W   = 16,
   parameter bit USE_MUL = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clear,
   input  logic                    step,
   input  logic [PPM_W-1:0]        step_ppm,
   output logic signed [DEV_W-1:0] dev,
   output logic                    upd,
   output logic                    last
);
   import ssc_prof_pkg::*;

   localparam int STEPS = 4 * QUARTER;
   localparam int POS_W = $clog2(STEPS);
   localparam int LVL_W = $clog2(QUARTER + 1) + 1;

   if (QUARTER < 1) begin : g_bad_quarter
      $error("ssc_tri_shaper: QUARTER must be at least 1");
   end

   logic [POS_W-1:0]        pos_q;
   logic signed [LVL_W-1:0] lvl_q;
   logic signed [LVL_W-1:0] lvl_n;
   logic                    climbing;
   logic signed [DEV_W-1:0] ppm_x;
   logic signed [DEV_W-1:0] dev_n;

   assign climbing = tri_climbing(int'(pos_q), QUARTER);
   assign lvl_n    = climbing ? lvl_q + LVL_W'(1) : lvl_q - LVL_W'(1);
   assign last     = step && (pos_q == POS_W'(STEPS - 1));
   assign ppm_x    = DEV_W'(step_ppm);

   generate
      if (USE_MUL) begin : g_mul
         logic signed [DEV_W-1:0] lvl_x;
         assign lvl_x = DEV_W'(lvl_n);
         assign dev_n = lvl_x * ppm_x;
      end else begin : g_acc
         assign dev_n = climbing ? dev + ppm_x : dev - ppm_x;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
         lvl_q <= '0;
         dev   <= '0;
         upd   <= 1'b0;
      end else if (clear) begin
         pos_q <= '0;
         lvl_q <= '0;
         dev   <= '0;
         upd   <= 1'b0;
      end else begin
         upd <= step;
         if (step) begin
            pos_q <= last ? '0 : pos_q + 1'b1;
            lvl_q <= lvl_n;
            dev   <= dev_n;
         end
      end
   end

endmodule

// File: rtl/ssc_profile_gen.sv
module ssc_profile_gen #(
   parameter int QUARTER       = 10,
   parameter int PEAK_UNIT_PPM = 2500,
   parameter int MULT_BASE     = 224,
   parameter int MULT_STEP     = 21,
   parameter int MULT_COUNT    = 5,
   parameter int RATE_W        = 3,
   parameter int SEL_W         = 3,
   parameter int DEV_W         = 16,
   parameter bit USE_MUL       = 1'b1
) (
   input  logic                    clk_ref,
   input  logic                    rst_n,
   input  logic [RATE_W-1:0]       rate_code,
   input  logic [SEL_W-1:0]        period_sel,
   input  logic                    pll_mode,
   input  logic                    src_bypass,
   output logic signed [DEV_W-1:0] dev_ppm,
   output logic                    dev_upd
);
   localparam int STEPS     = 4 * QUARTER;
   localparam int STEP_UNIT = PEAK_UNIT_PPM / QUARTER;
   localparam int RATE_MAX  = (2 ** RATE_W) - 1;
   localparam int PPM_W     = $clog2(RATE_MAX * STEP_UNIT + 1);
   localparam int PEAK_MAX  = RATE_MAX * PEAK_UNIT_PPM;
   localparam int MULT_MAX  = MULT_BASE + MULT_STEP * (MULT_COUNT - 1);
   localparam int LEN_W     = $clog2(MULT_MAX * (2 ** SEL_W) + 1);

   if (PEAK_UNIT_PPM % QUARTER != 0) begin : g_uneven_steps
      $error("ssc_profile_gen: PEAK_UNIT_PPM must divide by QUARTER");
   end
   if (PEAK_MAX >= 2 ** (DEV_W - 1)) begin : g_dev_too_narrow
      $error("ssc_profile_gen: DEV_W too small for the largest peak");
   end
   if (STEPS > 2 * MULT_BASE) begin : g_steps_too_dense
      $error("ssc_profile_gen: more steps than clocks in the shortest cycle");
   end

   logic             force_off;
   logic             run_q;
   logic             load;
   logic             step;
   logic             last;
   logic [LEN_W-1:0] cyc_len;
   logic [PPM_W-1:0] ppm_q;

   assign force_off = pll_mode | src_bypass;
   assign load      = (!run_q && !force_off) || last;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)
         run_q <= 1'b0;
      else
         run_q <= !force_off;
   end

   // Step size is captured only at a cycle boundary.
   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)
         ppm_q <= '0;
      else if (load && !force_off)
         ppm_q <= PPM_W'(rate_code) * PPM_W'(STEP_UNIT);
   end

   ssc_cycle_sched #(
      .MULT_BASE (MULT_BASE),
      .MULT_STEP (MULT_STEP),
      .MULT_COUNT(MULT_COUNT),
      .SEL_W     (SEL_W),
      .LEN_W     (LEN_W)
   ) sched_i (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .clear  (force_off),
      .load   (load),
      .sel    (period_sel),
      .cyc_len(cyc_len)
   );

   ssc_step_pacer #(
      .STEPS(STEPS),
      .LEN_W(LEN_W)
   ) pacer_i (
      .clk    (clk_ref),
      .rst_n  (rst_n),
      .clear  (force_off),
      .run    (run_q),
      .cyc_len(cyc_len),
      .step   (step)
   );

   ssc_tri_shaper #(
      .QUARTER(QUARTER),
      .PPM_W  (PPM_W),
      .DEV_W  (DEV_W),
      .USE_MUL(USE_MUL)
   ) shaper_i (
      .clk     (clk_ref),
      .rst_n   (rst_n),
      .clear   (force_off),
      .step    (step),
      .step_ppm(ppm_q),
      .dev     (dev_ppm),
      .upd     (dev_upd),
      .last    (last)
   );

endmodule

// File: rtl/ssc_prof_chk.sv
module ssc_prof_chk #(
   parameter int DEV_W    = 16,
   parameter int MAX_STEP = 1750,
   parameter int MAX_PEAK = 17500
) (
   input logic                    clk_ref,
   input logic                    rst_n,
   input logic                    pll_mode,
   input logic                    src_bypass,
   input logic signed [DEV_W-1:0] dev_ppm,
   input logic                    dev_upd
);
   logic signed [DEV_W-1:0] prev_q;
   logic                    force_q;
   logic signed [DEV_W:0]   delta;

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         force_q <= 1'b0;
      end else begin
         prev_q  <= dev_ppm;
         force_q <= pll_mode | src_bypass;
      end
   end

   assign delta = (DEV_W+1)'(dev_ppm) - (DEV_W+1)'(prev_q);

   assert_pll_zero_R7: assert property (@(posedge clk_ref) disable iff (!rst_n)
      pll_mode |=> (dev_ppm == '0 && !dev_upd));

   assert_bypass_zero_R8: assert property (@(posedge clk_ref) disable iff (!rst_n)
      src_bypass |=> (dev_ppm == '0 && !dev_upd));

   assert_peak_bound_R3: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (int'(dev_ppm) <= MAX_PEAK) && (int'(dev_ppm) >= -MAX_PEAK));

   assert_hold_between_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (!dev_upd && !force_q) |-> (dev_ppm == prev_q));

   assert_step_size_R2: assert property (@(posedge clk_ref) disable iff (!rst_n)
      dev_upd |-> ((int'(delta) <= MAX_STEP) && (int'(delta) >= -MAX_STEP)));

   assert_sparse_strobe_R4: assert property (@(posedge clk_ref) disable iff (!rst_n)
      dev_upd |=> !dev_upd);

endmodule

bind ssc_profile_gen ssc_prof_chk #(
   .DEV_W   (DEV_W),
   .MAX_STEP(((2 ** RATE_W) - 1) * (PEAK_UNIT_PPM / QUARTER)),
   .MAX_PEAK(((2 ** RATE_W) - 1) * PEAK_UNIT_PPM)
) chk_i (
   .clk_ref   (clk_ref),
   .rst_n     (rst_n),
   .pll_mode  (pll_mode),
   .src_bypass(src_bypass),
   .dev_ppm   (dev_ppm),
   .dev_upd   (dev_upd)
);

// File: tb/ssc_profile_gen_tb_top.sv
`timescale 1ns/1ps
module ssc_profile_gen_tb_top;

   localparam int QTR   = 10;
   localparam int NSTEP = 40;
   localparam int UNIT  = 250;

   logic               clk_ref = 1'b0;
   logic               rst_n;
   logic [2:0]         rate_code;
   logic [2:0]         period_sel;
   logic               pll_mode;
   logic               src_bypass;
   logic signed [15:0] dev_ppm;
   logic               dev_upd;

   int checks = 0;
   int errors = 0;

   always #2.5 clk_ref = ~clk_ref;

   ssc_profile_gen dut_i (
      .clk_ref   (clk_ref),
      .rst_n     (rst_n),
      .rate_code (rate_code),
      .period_sel(period_sel),
      .pll_mode  (pll_mode),
      .src_bypass(src_bypass),
      .dev_ppm   (dev_ppm),
      .dev_upd   (dev_upd)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int level_at(input int p);
      if (p <= QTR) return p;
      else if (p <= 3 * QTR) return 2 * QTR - p;
      else return p - 4 * QTR;
   endfunction

   // R1: reset state, then release at a falling edge.
   task automatic do_reset(input int rate, input int sel);
      @(negedge clk_ref);
      rst_n      = 1'b0;
      rate_code  = 3'(rate);
      period_sel = 3'(sel);
      pll_mode   = 1'b0;
      src_bypass = 1'b0;
      repeat (3) @(negedge clk_ref);
      check(dev_ppm == 0 && !dev_upd, "R1", "output during reset",
            int'(dev_ppm) + (dev_upd ? 100000 : 0), 0);
      rst_n = 1'b1;
   endtask

   // Watch one modulation cycle; optionally change inputs after step chg_at.
   task automatic watch_cycle(input int rate, input int lp1, input int mult,
                              input bit first, input int chg_at,
                              input int new_rate, input int new_sel,
                              input string req);
      int exp_len = mult * lp1 + (first ? 1 : 0);
      int clks    = 0;
      int n       = 0;
      int peak    = 0;
      int held    = 0;
      while (n < NSTEP && clks < exp_len + 10) begin
         @(negedge clk_ref);
         clks++;
         if (dev_upd) begin
            n++;
            check(int'(dev_ppm) == level_at(n) * rate * UNIT, "R2",
                  $sformatf("%s step %0d deviation", req, n),
                  int'(dev_ppm), level_at(n) * rate * UNIT);
            if (int'(dev_ppm) > peak) peak = int'(dev_ppm);
            if (n == chg_at) begin
               rate_code  = 3'(new_rate);
               period_sel = 3'(new_sel);
            end
            if (n == NSTEP)
               check(clks == exp_len, req, "cycle length", clks, exp_len);
         end else if (n == 0 && first) begin
            held |= (dev_ppm != 0);
         end
      end
      check(n == NSTEP, req, "steps per cycle", n, NSTEP);
      check(peak == rate * 2500, "R3", $sformatf("%s peak", req), peak, rate * 2500);
      if (first) check(held == 0, "R1", "deviation before first step", held, 0);
   endtask

   task automatic t_profile();
      int mults[5] = '{224, 245, 266, 287, 308};
      do_reset(7, 1);
      for (int i = 0; i < 6; i++)
         watch_cycle(7, 2, mults[i % 5], i == 0, 0, 0, 0, "R4");
   endtask

   task automatic t_rates();
      for (int r = 0; r < 7; r++) begin
         do_reset(r, 2);
         watch_cycle(r, 3, 224, 1'b1, 0, 0, 0, "R3");
      end
   endtask

   task automatic t_period_edges();
      do_reset(4, 0);
      watch_cycle(4, 2, 224, 1'b1, 0, 0, 0, "R5");
      do_reset(1, 7);
      watch_cycle(1, 8, 224, 1'b1, 0, 0, 0, "R4");
   endtask

   task automatic t_cfg_change();
      do_reset(2, 1);
      watch_cycle(2, 2, 224, 1'b1, 15, 5, 3, "R6");
      watch_cycle(5, 4, 245, 1'b0, 0, 0, 0, "R6");
   endtask

   task automatic t_force(input bit use_pll, input string req);
      int n   = 0;
      int bad = 0;
      do_reset(3, 1);
      while (n < 12) begin
         @(negedge clk_ref);
         if (dev_upd) n++;
      end
      check(int'(dev_ppm) == 6000, "R2", "deviation before forcing", int'(dev_ppm), 6000);
      if (use_pll) pll_mode = 1'b1; else src_bypass = 1'b1;
      rate_code = 3'd5;
      @(negedge clk_ref);
      check(dev_ppm == 0, req, "deviation one clock after force", int'(dev_ppm), 0);
      check(!dev_upd, req, "strobe one clock after force", int'(dev_upd), 0);
      repeat (300) begin
         @(negedge clk_ref);
         if (dev_upd || dev_ppm != 0) bad++;
      end
      check(bad == 0, req, "activity while forced", bad, 0);
      pll_mode   = 1'b0;
      src_bypass = 1'b0;
      watch_cycle(5, 2, 224, 1'b1, 0, 0, 0, "R9");
      watch_cycle(5, 2, 245, 1'b0, 0, 0, 0, "R9");
   endtask

   initial begin
      repeat (150000) @(posedge clk_ref);
      errors++;
      $display("FAIL watchdog: actual 150000 cycles expected completion earlier");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      rst_n      = 1'b0;
      rate_code  = '0;
      period_sel = '0;
      pll_mode   = 1'b0;
      src_bypass = 1'b0;
      t_profile();
      t_rates();
      t_period_edges();
      t_cfg_change();
      t_force(1'b1, "R7");
      t_force(1'b0, "R8");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule